// File: doc/BRIEF.md
# SPI Slave Register Access Front End

This block lets an SPI master reach a 64-byte space of clock registers, control registers and user RAM. The master lowers the active-low select, sends one command byte and then moves any number of data bytes. The command's top bit picks the direction and its low six bits give the start address. The block turns the serial traffic into byte-wide read and write cycles on a simple register-file port. It steps the pointer after every data byte, wrapping at the top of the space, so a burst can run for as long as the select stays low.

All SPI pins are brought into the system clock domain through two-flop synchronisers, and edges are detected on the synchronised copies. The serial clock must therefore be several times slower than the system clock. An output tells the timekeeping logic to freeze its user-visible copy while the pointer sits on the eight clock registers. A power-fail input ends any transfer at once and ignores the pins.

Top module: `spi_reg_slave`

## Requirements
- R1: SDI is taken on the rising edge of SCL and SDO changes only after a falling edge of SCL. Both idle-low (mode 0) and idle-high (mode 3) serial clocks work.
- R2: Bits arrive most significant bit first. Bit 7 of the command byte (the first bit after select falls) set to 1 means write and set to 0 means read.
- R3: Command bits 5..0 give the start address. Command bit 6 has no effect, so 0x45 and 0x05 reach the same byte.
- R4: While select stays low, the pointer advances by one after each data byte and wraps from 0x3F to 0x00.
- R5: sdo_oe is low while select is high and during the command byte. It goes high with the first data bit driven in a read.
- R6: After reset, a transfer starts only on a high-to-low select transition seen after reset. A select already held low through reset starts nothing.
- R7: While pwr_fail is high, the transfer is aborted, reg_addr goes to 0 and no strobes are issued. Once pwr_fail falls, nothing happens until a fresh select fall.
- R8: hold_upd is high while a data phase is open with the pointer at 0x00..0x07. It is low once the pointer reaches 0x08 or more, and low after deselect.
- R9: Each received write byte produces exactly one single-cycle reg_we, with reg_addr and reg_wdata valid in that cycle, after the byte's eighth bit.
- R10: A read of N bytes issues N+1 single-cycle reg_re pulses (one prefetch per byte). reg_rdata is taken in the reg_re cycle, before the byte's first SDO bit.
- R11: After reset, reg_we, reg_re, sdo_oe and hold_upd are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | SPI serial clock |
| sdi | input | 1 | SPI data from master |
| cs_n | input | 1 | Active-low select |
| pwr_fail | input | 1 | Power-fail abort, synchronous to clk |
| sdo | output | 1 | SPI data to master |
| sdo_oe | output | 1 | Drive enable for sdo (high-Z when low) |
| reg_addr | output | 6 | Register file address |
| reg_wdata | output | 8 | Register file write data |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_re | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 8 | Register file read data, valid in the reg_re cycle |
| hold_upd | output | 1 | Freeze request for the clock registers |

## Verification
The bench writes bursts that cross the 0x3F boundary, and a design that failed to wrap would write to 0x40 or stall. It also sends a command with bit 6 set, which a design that decoded seven address bits would send to the wrong byte. It holds select low through reset, where a design that saw reset as a select edge would accept writes. It raises pwr_fail in mid-byte and keeps clocking with select still low after release; a design that did not demand a fresh select fall would write garbage there. Finally, it walks a write across 0x07 into 0x08 to show that hold_upd drops exactly at the clock-range boundary and on deselect.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMD  = 2'd1,
    PH_DATA = 2'd2
  } phase_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
      s3_q <= RST_VAL;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign dout = s2_q;
  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_reg_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 6,
  parameter int CLK_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sdi_s,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              pwr_fail,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              we,
  output logic              re,
  output logic              sdo_bit,
  output logic              oe,
  output logic              hold
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  phase_t              phase_q, phase_d;
  logic [BIT_W-1:0]    bit_q, bit_d;
  logic [DATA_W-1:0]   rx_q, rx_d, tx_q, tx_d, wdata_q, wdata_d;
  logic [ADDR_W-1:0]   ptr_q, ptr_d;
  logic                wr_q, wr_d, we_q, we_d, re_q, re_d;
  logic                sdo_q, sdo_d, oe_q, oe_d;
  logic [DATA_W-1:0]   rx_byte;

  assign rx_byte = {rx_q[DATA_W-2:0], sdi_s};

  always_comb begin
    phase_d = phase_q;
    bit_d   = bit_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    wdata_d = wdata_q;
    ptr_d   = ptr_q;
    wr_d    = wr_q;
    sdo_d   = sdo_q;
    oe_d    = oe_q;
    we_d    = 1'b0;
    re_d    = 1'b0;
    if (pwr_fail) begin
      phase_d = PH_IDLE;
      bit_d   = '0;
      ptr_d   = '0;
      oe_d    = 1'b0;
    end else begin
      if (we_q) ptr_d = ptr_q + 1'b1;
      if (re_q) tx_d = rdata;
      if (cs_fall) begin
        phase_d = PH_CMD;
        bit_d   = '0;
        oe_d    = 1'b0;
      end else if (cs_rise) begin
        phase_d = PH_IDLE;
        oe_d    = 1'b0;
      end else if (phase_q != PH_IDLE) begin
        if (scl_rise) begin
          rx_d  = rx_byte;
          bit_d = (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
          if (bit_q == LAST_BIT) begin
            if (phase_q == PH_CMD) begin
              wr_d    = rx_byte[DATA_W-1];
              ptr_d   = rx_byte[ADDR_W-1:0];
              re_d    = ~rx_byte[DATA_W-1];
              phase_d = PH_DATA;
            end else if (wr_q) begin
              we_d    = 1'b1;
              wdata_d = rx_byte;
            end else begin
              ptr_d = ptr_q + 1'b1;
              re_d  = 1'b1;
            end
          end
        end
        if (scl_fall && phase_q == PH_DATA && !wr_q) begin
          sdo_d = tx_q[DATA_W-1];
          tx_d  = {tx_q[DATA_W-2:0], 1'b0};
          oe_d  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
      ptr_q   <= '0;
      wr_q    <= 1'b0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      sdo_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      wdata_q <= wdata_d;
      ptr_q   <= ptr_d;
      wr_q    <= wr_d;
      we_q    <= we_d;
      re_q    <= re_d;
      sdo_q   <= sdo_d;
      oe_q    <= oe_d;
    end
  end

  assign addr    = ptr_q;
  assign wdata   = wdata_q;
  assign we      = we_q;
  assign re      = re_q;
  assign sdo_bit = sdo_q;
  assign oe      = oe_q;
  assign hold    = (phase_q == PH_DATA) && (ptr_q < ADDR_W'(CLK_REGS));
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 6,
  parameter int CLK_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl,
  input  logic              sdi,
  input  logic              cs_n,
  input  logic              pwr_fail,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              hold_upd
);
  localparam int N_SYNC = 3;
  localparam int IX_CS  = 2;
  localparam int IX_SCL = 1;
  localparam int IX_SDI = 0;

  logic [N_SYNC-1:0] s_dat, s_rise, s_fall;
  logic              oe_int;

  // select resets to "low" so a select held low through reset is no edge (R6)
  spi_sync #(.W(N_SYNC), .RST_VAL('0)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({cs_n, scl, sdi}),
    .dout (s_dat),
    .rise (s_rise),
    .fall (s_fall)
  );

  spi_xfer_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLK_REGS(CLK_REGS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_rise(s_rise[IX_SCL]),
    .scl_fall(s_fall[IX_SCL]),
    .sdi_s   (s_dat[IX_SDI]),
    .cs_fall (s_fall[IX_CS]),
    .cs_rise (s_rise[IX_CS]),
    .pwr_fail(pwr_fail),
    .rdata   (reg_rdata),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .we      (reg_we),
    .re      (reg_re),
    .sdo_bit (sdo),
    .oe      (oe_int),
    .hold    (hold_upd)
  );

  assign sdo_oe = oe_int & ~cs_n & ~pwr_fail;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int ADDR_W   = 6,
  parameter int CLK_REGS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_fail,
  input logic              reg_we,
  input logic              reg_re,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              hold_upd
);
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);  // R9
  AST_NO_WE_RE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));  // R10
  AST_PF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (!reg_we && !reg_re));  // R7
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !pwr_fail) |=> (reg_addr == ADDR_W'($past(reg_addr) + 1'b1)));  // R4
  AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_upd |-> (reg_addr < ADDR_W'(CLK_REGS)));  // R8
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.ADDR_W(ADDR_W), .CLK_REGS(CLK_REGS)) u_chk (.*);

// File: tb/tb_spi_reg_slave.sv
module tb_spi_reg_slave;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b0, sdi = 1'b0, cs_n = 1'b1, pwr_fail = 1'b0;
  logic sdo, sdo_oe, reg_we, reg_re, hold_upd;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [64];
  int n_chk = 0, n_fail = 0, we_cnt = 0, re_cnt = 0;

  always #4 clk = ~clk;

  spi_reg_slave dut (.*);

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'h00;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end
  always @(posedge clk) begin
    if (reg_we) we_cnt <= we_cnt + 1;
    if (reg_re) re_cnt <= re_cnt + 1;
  end

  // {mode3, command address, byte count, data seed, expected start address}
  localparam logic [39:0] VEC [4] = '{
    {8'h00, 8'h10, 8'd3, 8'hA1, 8'h10},
    {8'h01, 8'h45, 8'd2, 8'h5C, 8'h05},
    {8'h00, 8'h3E, 8'd4, 8'h30, 8'h3E},
    {8'h01, 8'h20, 8'd1, 8'hFF, 8'h20}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sel(input logic m3);
    scl = m3;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel(input logic m3);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    scl = m3;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic xbyte(input logic m3, input logic [7:0] tx,
                       output logic [7:0] rx, output logic oe_all);
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      if (m3) scl = 1'b0;
      sdi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = sdo;
      oe_all = oe_all & sdo_oe;
      scl = 1'b1;
      repeat (HALF) @(negedge clk);
      if (!m3) scl = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] rx;
    logic oe;
    int w0, r0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 reset we", reg_we, 0);
    check("R11 reset re", reg_re, 0);
    check("R11 reset oe", sdo_oe, 0);
    check("R11 reset hold", hold_upd, 0);

    foreach (VEC[v]) begin
      logic m3;
      logic [7:0] ca, n, sd, ex;
      {m3, ca, n, sd, ex} = {VEC[v][32], VEC[v][31:0]};
      w0 = we_cnt;
      sel(m3);
      xbyte(m3, 8'h80 | ca, rx, oe);            // R2 write
      for (int i = 0; i < n; i++) xbyte(m3, sd + 8'(i), rx, oe);
      desel(m3);
      check("R9 write strobes", we_cnt - w0, n);
      for (int i = 0; i < n; i++)
        check("R3 R4 write location", mem[(ex + i) & 8'h3F], sd + 8'(i));
      r0 = re_cnt;
      sel(!m3);
      xbyte(!m3, ca & 8'h7F, rx, oe);           // R2 read
      check("R5 oe low during command", oe, 0);
      for (int i = 0; i < n; i++) begin
        xbyte(!m3, 8'h00, rx, oe);
        check("R1 R4 read data", rx, sd + 8'(i));
        check("R5 oe during read data", oe, 1);
      end
      desel(!m3);
      check("R10 read strobes", re_cnt - r0, n + 1);
      check("R5 oe after deselect", sdo_oe, 0);
    end

    // R8 hold across 0x07 -> 0x08 in a write
    sel(1'b0);
    xbyte(1'b0, 8'h86, rx, oe);
    repeat (4) @(negedge clk);
    check("R8 hold at 06", hold_upd, 1);
    xbyte(1'b0, 8'h11, rx, oe);
    repeat (4) @(negedge clk);
    check("R8 hold at 07", hold_upd, 1);
    xbyte(1'b0, 8'h22, rx, oe);
    repeat (4) @(negedge clk);
    check("R8 hold released at 08", hold_upd, 0);
    desel(1'b0);
    check("R8 write 07", mem[7], 8'h22);
    sel(1'b1);
    xbyte(1'b1, 8'h02, rx, oe);
    repeat (4) @(negedge clk);
    check("R8 hold in read", hold_upd, 1);
    desel(1'b1);
    check("R8 hold after deselect", hold_upd, 0);

    // R7 power-fail abort
    w0 = we_cnt;
    r0 = re_cnt;
    sel(1'b0);
    xbyte(1'b0, 8'hAA, rx, oe);
    pwr_fail = 1'b1;
    xbyte(1'b0, 8'h5A, rx, oe);
    check("R7 pointer cleared", reg_addr, 0);
    check("R7 oe low", sdo_oe, 0);
    pwr_fail = 1'b0;
    xbyte(1'b0, 8'h77, rx, oe);
    xbyte(1'b0, 8'h66, rx, oe);
    check("R7 no writes", we_cnt - w0, 0);
    check("R7 target untouched", mem[8'h2A], 8'h00);
    desel(1'b0);
    sel(1'b0);
    xbyte(1'b0, 8'hAA, rx, oe);
    xbyte(1'b0, 8'h3C, rx, oe);
    desel(1'b0);
    check("R7 recovery write", mem[8'h2A], 8'h3C);

    // R6 select held low through reset
    cs_n = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    w0 = we_cnt;
    r0 = re_cnt;
    xbyte(1'b0, 8'h81, rx, oe);
    xbyte(1'b0, 8'hEE, rx, oe);
    check("R6 no write without select edge", we_cnt - w0, 0);
    check("R6 no read without select edge", re_cnt - r0, 0);
    check("R6 address byte untouched", mem[1], 8'h00);
    desel(1'b0);
    finish_run();
  end
endmodule